// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Receive Queue

This block is the receive half of an asynchronous serial port. A 16x oversampling tick from an external baud generator paces a sampler. The sampler qualifies each start bit and reads every following bit near its centre. It reassembles characters of 5 to 8 data bits, with optional even or odd parity. Each finished character goes into a 16-entry queue. Every entry holds the data byte and a 3-bit error tag.

The host pops entries one at a time through a registered read port. The host also sees the fill level and an interrupt request. The request is raised once the level reaches a programmable threshold. When a character arrives and the queue has no room, the character is lost. A sticky overrun flag then stays set until the host clears it.

Top module: `serrx_top`

## Requirements
- R1: After synchronous reset, `level` is 0 and `irq`, `ovr_flag` and `rd_valid` are all 0.
- R2: A low line seen on a tick starts a frame only if the line is still low 8 ticks later. If it is high at that point, the receiver returns to idle and stores nothing.
- R3: Data bits are taken LSB first, one every 16 ticks after the start-bit midpoint. `cfg_len` selects 5+`cfg_len` data bits (0=5, 1=6, 2=7, 3=8). Unused upper bits of the stored byte are 0.
- R4: With `cfg_par_en`=1 a parity bit follows the data. Odd parity is used when `cfg_par_odd`=1, even parity otherwise. A mismatch sets tag bit 0 (`rd_err[0]`). With `cfg_par_en`=0 that bit is always 0.
- R5: A stop bit sampled low sets tag bit 1 (`rd_err[1]`). After such a frame, no new start is accepted until the line has returned high.
- R6: Tag bit 2 (`rd_err[2]`) is set when the data bits, the parity bit (if enabled) and the stop bit were all sampled low.
- R7: The queue returns characters in arrival order. A pulse on `rd_en` while `level`>0 removes the oldest entry and presents it on `rd_data`/`rd_err` with `rd_valid`=1 in the next cycle. `rd_en` while `level`=0 has no effect and gives no `rd_valid`.
- R8: A character completed while 16 entries are held and no read is taken in that cycle is discarded. It also sets `ovr_flag`, which stays 1 until a pulse on `ovr_clr`. If a new overrun occurs in the same cycle as the clear, the flag stays set.
- R9: A character completed in the same cycle as an accepted read from a full queue is stored, `level` stays 16 and `ovr_flag` is not set.
- R10: `level` gives the number of stored entries. `irq` is 1 one cycle after `level`>=`cfg_thresh`, provided `cfg_thresh` is not 0. A threshold of 0 keeps `irq` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_thresh | input | 5 | Fill level that raises `irq`, 0 disables |
| rd_en | input | 1 | Pop one entry |
| ovr_clr | input | 1 | Clear the overrun flag |
| rd_valid | output | 1 | `rd_data`/`rd_err` hold a popped entry |
| rd_data | output | 8 | Popped data byte |
| rd_err | output | 3 | Popped tag: bit0 parity, bit1 framing, bit2 break |
| level | output | 5 | Entries held, 0 to 16 |
| irq | output | 1 | Fill level at or above threshold |
| ovr_flag | output | 1 | Sticky overrun indication |

## Verification
The collision that matters is a character finishing in the very cycle a read removes an entry from a full queue. The bench first records, from the `level` port, how many clocks separate the start of a frame from its store. It then replays a frame into a full queue and pulses `rd_en` in exactly that cycle. It judges the result by `level` holding at 16 and `ovr_flag` staying 0. It then drains the queue and checks that the popped order ends with the colliding character, followed by nothing further, because a later frame sent with no read was dropped.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAITHI
  } rx_state_t;

  // tag layout: bit0 parity, bit1 framing, bit2 break
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_err_t;

  localparam int ERR_W  = 3;
  localparam int BYTE_W = 8;

endpackage

// File: rtl/serrx_sampler.sv
module serrx_sampler
  import serrx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        rxd_async,
  input  logic [1:0]  cfg_len,
  input  logic        cfg_par_en,
  input  logic        cfg_par_odd,
  output logic        chr_push,
  output logic [7:0]  chr_data,
  output rx_err_t     chr_err
);

  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic       s1, s2;
  rx_state_t  state;
  logic [CW-1:0] tcnt;
  logic [2:0] bidx;
  logic [2:0] last_idx;
  logic [7:0] shreg;
  logic       par_q;
  logic [1:0] len_q;
  logic       pen_q;
  logic       podd_q;
  logic       exp_par;
  rx_err_t    err_nx;

  // two-flop synchronizer, idle high
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd_async;
      s2 <= s1;
    end
  end

  assign last_idx = 3'd4 + {1'b0, len_q};
  assign exp_par  = (^shreg) ^ podd_q;

  always_comb begin
    err_nx.par = pen_q && (par_q != exp_par);
    err_nx.frm = !s2;
    err_nx.brk = !s2 && (shreg == 8'h00) && (!pen_q || !par_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      tcnt     <= '0;
      bidx     <= '0;
      shreg    <= '0;
      par_q    <= 1'b0;
      len_q    <= 2'd3;
      pen_q    <= 1'b0;
      podd_q   <= 1'b0;
      chr_push <= 1'b0;
      chr_data <= '0;
      chr_err  <= '0;
    end else begin
      chr_push <= 1'b0;
      if (state == ST_WAITHI) begin
        if (s2) state <= ST_IDLE;
      end else if (tick) begin
        case (state)
          ST_IDLE: begin
            if (!s2) begin
              state  <= ST_START;
              tcnt   <= '0;
              len_q  <= cfg_len;
              pen_q  <= cfg_par_en;
              podd_q <= cfg_par_odd;
            end
          end
          ST_START: begin
            if (tcnt == MID) begin
              tcnt  <= '0;
              bidx  <= '0;
              shreg <= '0;
              par_q <= 1'b0;
              state <= s2 ? ST_IDLE : ST_DATA;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (tcnt == LAST) begin
              tcnt        <= '0;
              shreg[bidx] <= s2;
              if (bidx == last_idx) state <= pen_q ? ST_PAR : ST_STOP;
              else                  bidx  <= bidx + 1'b1;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (tcnt == LAST) begin
              tcnt  <= '0;
              par_q <= s2;
              state <= ST_STOP;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (tcnt == LAST) begin
              tcnt     <= '0;
              chr_push <= 1'b1;
              chr_data <= shreg;
              chr_err  <= err_nx;
              state    <= s2 ? ST_IDLE : ST_WAITHI;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_START_REJECT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && tick && tcnt == MID && s2) |=> (state == ST_IDLE && !chr_push)); // R2
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (chr_push && len_q == 2'd0) |-> (chr_data[7:5] == 3'b000)); // R3
  AST_NO_PAR_ERR_OFF: assert property (@(posedge clk) disable iff (rst)
    (chr_push && !pen_q) |-> !chr_err.par); // R4
  AST_BRK_HAS_FRM: assert property (@(posedge clk) disable iff (rst)
    (chr_push && chr_err.brk) |-> chr_err.frm); // R6
  AST_WAIT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAITHI && !s2) |=> (state == ST_WAITHI)); // R5

endmodule

// File: rtl/serrx_fifo.sv
module serrx_fifo #(
  parameter int DW    = 11,
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  input  logic          ovr_clr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [LW-1:0] count,
  output logic          ovr
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LW-1:0] FULL_CNT = LW'(DEPTH);
  localparam logic [AW-1:0] TOP_PTR  = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic full, empty, rd_ok, wr_ok;

  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);
  assign rd_ok = rd_req && !empty;
  assign wr_ok = wr_req && (!full || rd_ok);

  // storage without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
    if (rd_ok) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      rd_valid <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      rd_valid <= rd_ok;
      if (wr_ok) wptr <= (wptr == TOP_PTR) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr <= (rptr == TOP_PTR) ? '0 : rptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr_req && !wr_ok) ovr <= 1'b1;
      else if (ovr_clr)     ovr <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT); // R7
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (rd_req && count == '0) |=> !rd_valid); // R7
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (wr_req && full && !rd_req) |=> (ovr && count == FULL_CNT)); // R8
  AST_COLLIDE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr_req && rd_req && full && !ovr) |=> (count == FULL_CNT && !ovr)); // R9

endmodule

// File: rtl/serrx_top.sv
module serrx_top
  import serrx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         os_tick,
  input  logic                         rxd,
  input  logic [1:0]                   cfg_len,
  input  logic                         cfg_par_en,
  input  logic                         cfg_par_odd,
  input  logic [$clog2(DEPTH+1)-1:0]   cfg_thresh,
  input  logic                         rd_en,
  input  logic                         ovr_clr,
  output logic                         rd_valid,
  output logic [BYTE_W-1:0]            rd_data,
  output logic [ERR_W-1:0]             rd_err,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         irq,
  output logic                         ovr_flag
);

  localparam int LW = $clog2(DEPTH + 1);
  localparam int DW = BYTE_W + ERR_W;

  logic          push;
  logic [7:0]    pdata;
  rx_err_t       perr;
  logic [DW-1:0] qout;

  serrx_sampler #(.OSR(OSR)) u_smp (
    .clk        (clk),
    .rst        (rst),
    .tick       (os_tick),
    .rxd_async  (rxd),
    .cfg_len    (cfg_len),
    .cfg_par_en (cfg_par_en),
    .cfg_par_odd(cfg_par_odd),
    .chr_push   (push),
    .chr_data   (pdata),
    .chr_err    (perr)
  );

  serrx_fifo #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_q (
    .clk     (clk),
    .rst     (rst),
    .wr_req  (push),
    .wr_data ({perr, pdata}),
    .rd_req  (rd_en),
    .ovr_clr (ovr_clr),
    .rd_data (qout),
    .rd_valid(rd_valid),
    .count   (level),
    .ovr     (ovr_flag)
  );

  assign rd_data = qout[BYTE_W-1:0];
  assign rd_err  = qout[DW-1:BYTE_W];

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (cfg_thresh != '0) && (level >= cfg_thresh);
  end

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(cfg_thresh) != '0 && $past(level) >= $past(cfg_thresh))); // R10
  AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |=> !irq); // R10

endmodule

// File: tb/sim_serrx_top.sv
module sim_serrx_top;

  localparam int CLK_PERIOD = 10;
  localparam int BIT_T = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 1'b0;
  logic cfg_par_odd = 1'b0;
  logic [4:0] cfg_thresh = 5'd0;
  logic rd_en = 1'b0;
  logic ovr_clr = 1'b0;
  logic rd_valid;
  logic [7:0] rd_data;
  logic [2:0] rd_err;
  logic [4:0] level;
  logic irq;
  logic ovr_flag;

  int n_chk = 0;
  int n_fail = 0;
  int calib_k = 0;
  logic [10:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  serrx_top u0 (
    .clk(clk), .rst(rst), .os_tick(1'b1), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_thresh(cfg_thresh), .rd_en(rd_en), .ovr_clr(ovr_clr),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
    .level(level), .irq(irq), .ovr_flag(ovr_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: sends a frame and records the expected queue item
  task automatic send_char(input logic [7:0] d, input bit flip_par, input bit stop_lvl,
                           input bit store, input string tag);
    int nb;
    logic [7:0] dm;
    logic pbit;
    nb = 5 + int'(cfg_len);
    dm = d & ((8'h01 << nb) - 8'h01);
    pbit = (^dm) ^ cfg_par_odd ^ flip_par;
    @(negedge clk);
    rxd = 1'b0;
    repeat (BIT_T) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = dm[i];
      repeat (BIT_T) @(negedge clk);
    end
    if (cfg_par_en) begin
      rxd = pbit;
      repeat (BIT_T) @(negedge clk);
    end
    rxd = stop_lvl;
    repeat (BIT_T) @(negedge clk);
    rxd = 1'b1;
    repeat (BIT_T) @(negedge clk);
    if (store) begin
      exp_q.push_back({(!stop_lvl && dm == 8'h00 && (!cfg_par_en || !pbit)),
                       !stop_lvl, (cfg_par_en && flip_par), dm});
      tag_q.push_back(tag);
    end
  endtask

  // monitor: compares every popped entry with the scoreboard
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected entry", int'({rd_err, rd_data}), 0);
      end else begin
        logic [10:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({rd_err, rd_data} == e, t, int'({rd_err, rd_data}), int'(e));
      end
    end
  end

  task automatic drain();
    while (level != 5'd0) begin
      @(negedge clk) rd_en = 1'b1;
      @(negedge clk) rd_en = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7 scoreboard empty after drain", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(level == 0, "R1 level", level, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(ovr_flag == 0, "R1 ovr_flag", ovr_flag, 0);
    chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);

    // R7: read from an empty queue
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
    chk(rd_valid == 0, "R7 empty read", rd_valid, 0);

    // R2: short low pulse is not a start
    rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (3 * BIT_T) @(negedge clk);
    chk(level == 0, "R2 glitch stored nothing", level, 0);

    // R3: 8 and 5 data bits, no parity
    send_char(8'hA5, 0, 1, 1, "R3 8N A5");
    send_char(8'h3C, 0, 1, 1, "R3 8N 3C");
    cfg_len = 2'd0;
    send_char(8'hFF, 0, 1, 1, "R3 5N upper zero");
    cfg_len = 2'd2;
    send_char(8'h6B, 0, 1, 1, "R3 7N");
    drain();

    // R4: parity
    cfg_len = 2'd2; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send_char(8'h55, 0, 1, 1, "R4 7E good");
    send_char(8'h55, 1, 1, 1, "R4 7E bad");
    cfg_len = 2'd1; cfg_par_odd = 1'b1;
    send_char(8'h2A, 0, 1, 1, "R4 6O good");
    send_char(8'h2A, 1, 1, 1, "R4 6O bad");
    drain();

    // R5 / R6: framing and break
    cfg_len = 2'd3; cfg_par_odd = 1'b0;
    send_char(8'h81, 0, 0, 1, "R5 framing");
    send_char(8'h00, 0, 0, 1, "R6 break even");
    cfg_par_odd = 1'b1;
    send_char(8'h00, 1, 0, 1, "R6 break odd forced low parity");
    send_char(8'h00, 0, 0, 1, "R6 zero data high parity no break");
    drain();

    // R10: threshold
    cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_thresh = 5'd4;
    for (int i = 0; i < 3; i++) send_char(8'(i + 1), 0, 1, 1, "R10 fill");
    @(negedge clk);
    chk(level == 3, "R10 level 3", level, 3);
    chk(irq == 0, "R10 below threshold", irq, 0);
    send_char(8'h44, 0, 1, 1, "R10 fill");
    @(negedge clk);
    chk(irq == 1, "R10 at threshold", irq, 1);
    cfg_thresh = 5'd0;
    repeat (2) @(negedge clk);
    chk(irq == 0, "R10 threshold zero", irq, 0);
    cfg_thresh = 5'd4;

    // calibrate store latency on the 5th entry
    fork
      send_char(8'h50, 0, 1, 1, "R7 order");
      begin
        logic [4:0] l0;
        @(negedge clk);
        l0 = level;
        calib_k = 0;
        forever begin
          @(posedge clk);
          calib_k++;
          @(negedge clk);
          if (level != l0) break;
        end
      end
    join
    for (int i = 6; i <= 16; i++) send_char(8'(8'h50 + i), 0, 1, 1, "R7 order");
    @(negedge clk);
    chk(level == 16, "R7 full", level, 16);

    // R9: store and read in the same cycle
    fork
      send_char(8'hC9, 0, 1, 1, "R9 collided entry");
      begin
        @(negedge clk);
        repeat (calib_k - 1) @(posedge clk);
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
      end
    join
    @(negedge clk);
    chk(level == 16, "R9 level held", level, 16);
    chk(ovr_flag == 0, "R9 no overrun", ovr_flag, 0);

    // R8: overrun drop and sticky flag
    send_char(8'hEE, 0, 1, 0, "R8 dropped");
    @(negedge clk);
    chk(ovr_flag == 1, "R8 overrun set", ovr_flag, 1);
    chk(level == 16, "R8 level unchanged", level, 16);
    repeat (5) @(negedge clk);
    chk(ovr_flag == 1, "R8 sticky", ovr_flag, 1);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0; @(negedge clk);
    chk(ovr_flag == 0, "R8 cleared", ovr_flag, 0);
    drain();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule